// File: doc/BRIEF.md
# Latched Interrupt Aggregation Controller

This block gathers a vector of interrupt lines from peripherals and folds them into a single request toward a parent interrupt controller. Each raw line first passes through a two-stage synchronizer. It is then either captured as a sticky pending bit on its rising edge (latched layout) or shown directly as a level (level layout). A per-source mask, where a set bit disables the source, gates which pending sources may raise the combined request.

Software reaches the block through a small word-wide register port. Each write is a single-cycle strobe with an address and data. Read data is combinational from the address. The mask is never written directly. One register sets mask bits for each 1 written and another clears them. A third register, present only in the latched layout, acknowledges pending bits. The layout is chosen at elaboration time, and the register offsets shift with it.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset the mask reads all ones, status reads zero and `irq_o` is low.
- R2: Latched layout: a 0-to-1 change on `src_i[n]` sets status bit n three rising clock edges after the change is applied (two synchronizer stages, then the capture register). Status is read at offset 0x00.
- R3: Latched layout: writing offset 0x08 clears each status bit whose data bit is 1. Bits written as 0 keep their status.
- R4: Latched layout: when a new edge and an acknowledge of the same bit fall in the same cycle, the bit stays set. An input that stays high produces no second capture after it has been acknowledged.
- R5: Writing the mask-set offset (0x10 latched, 0x08 level) sets each mask bit written as 1. Writing the mask-clear offset (0x14 latched, 0x0C level) clears each mask bit written as 1. Zero bits leave the mask alone. The mask reads back at 0x0C (latched) or 0x04 (level), and a 1 means the source is disabled.
- R6: `irq_o` is high exactly when some source is both set in status and clear in the mask.
- R7: Masking a source keeps its pending status, which stays readable while masked.
- R8: Level layout: status at 0x00 follows the synchronized input levels, two edges behind `src_i`. It has no acknowledge register.
- R9: Reads of any offset other than the status and mask-status offsets return zero. This includes the write-only set, clear and acknowledge offsets. Writes to unmapped offsets change nothing.
- R10: Latched layout: a captured status bit stays set after its input returns low, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NUM_SRC | Raw interrupt lines, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
The bench aims an acknowledge at the exact cycle in which a fresh edge is captured. A design that lets the clear win would lose that interrupt, and one that samples levels instead of edges would re-capture a line that is still high after its acknowledge. It reads status while the source is masked and after the input has dropped. A design that discards pending state on mask, or forgets it when the line falls, would read zero there. It also writes the offsets that belong to the other layout. A decoder that ignores the mode would then unmask sources or return data where only zero is allowed.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    // Register selected by an access
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ACK,
        SEL_MSTAT,
        SEL_MSET,
        SEL_MCLR
    } reg_sel_e;

    // Write strobes derived from one bus write
    typedef struct packed {
        logic ack;
        logic mset;
        logic mclr;
    } wr_strobe_t;

    // Latched layout offsets
    localparam logic [31:0] LAT_STATUS = 32'h00;
    localparam logic [31:0] LAT_ACK    = 32'h08;
    localparam logic [31:0] LAT_MSTAT  = 32'h0C;
    localparam logic [31:0] LAT_MSET   = 32'h10;
    localparam logic [31:0] LAT_MCLR   = 32'h14;

    // Level layout offsets
    localparam logic [31:0] LVL_STATUS = 32'h00;
    localparam logic [31:0] LVL_MSTAT  = 32'h04;
    localparam logic [31:0] LVL_MSET   = 32'h08;
    localparam logic [31:0] LVL_MCLR   = 32'h0C;

    function automatic reg_sel_e decode_sel(input logic [31:0] addr, input bit latched);
        reg_sel_e sel;
        sel = SEL_NONE;
        if (latched) begin
            case (addr)
                LAT_STATUS: sel = SEL_STATUS;
                LAT_ACK:    sel = SEL_ACK;
                LAT_MSTAT:  sel = SEL_MSTAT;
                LAT_MSET:   sel = SEL_MSET;
                LAT_MCLR:   sel = SEL_MCLR;
                default:    sel = SEL_NONE;
            endcase
        end else begin
            case (addr)
                LVL_STATUS: sel = SEL_STATUS;
                LVL_MSTAT:  sel = SEL_MSTAT;
                LVL_MSET:   sel = SEL_MSET;
                LVL_MCLR:   sel = SEL_MCLR;
                default:    sel = SEL_NONE;
            endcase
        end
        return sel;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= '0;
                else     chain_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= '0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_pend.sv
module irq_pend #(
    parameter int W       = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] ack_i,
    output logic [W-1:0] status_o,
    output logic [W-1:0] edge_o
);
    if (LATCHED) begin : g_latched
        logic [W-1:0] prev_q;
        logic [W-1:0] pend_q;

        assign edge_o = lvl_i & ~prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= '0;
                pend_q <= '0;
            end else begin
                prev_q <= lvl_i;
                // a new edge overrides an acknowledge of the same bit
                pend_q <= (pend_q & ~ack_i) | edge_o;
            end
        end

        assign status_o = pend_q;
    end else begin : g_level
        logic unused_ack;
        assign unused_ack = ^ack_i;
        assign edge_o     = '0;
        assign status_o   = lvl_i;
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) mask_q <= '1;
        else     mask_q <= (mask_q | set_i) & ~clr_i;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/irq_regif.sv
module irq_regif
    import irq_agg_pkg::*;
#(
    parameter int W       = 32,
    parameter int AW      = 8,
    parameter bit LATCHED = 1'b1
) (
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic [W-1:0]  status_i,
    input  logic [W-1:0]  mask_i,
    output logic [W-1:0]  ack_o,
    output logic [W-1:0]  set_o,
    output logic [W-1:0]  clr_o,
    output logic [W-1:0]  rdata_o
);
    logic [31:0] addr32;
    reg_sel_e    sel;
    wr_strobe_t  stb;

    assign addr32 = 32'(addr_i);
    assign sel    = decode_sel(addr32, LATCHED);

    always_comb begin
        stb      = '0;
        stb.ack  = wr_i && (sel == SEL_ACK);
        stb.mset = wr_i && (sel == SEL_MSET);
        stb.mclr = wr_i && (sel == SEL_MCLR);
    end

    assign ack_o = stb.ack  ? wdata_i : '0;
    assign set_o = stb.mset ? wdata_i : '0;
    assign clr_o = stb.mclr ? wdata_i : '0;

    always_comb begin
        case (sel)
            SEL_STATUS: rdata_o = status_i;
            SEL_MSTAT:  rdata_o = mask_i;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl #(
    parameter int NUM_SRC      = 32,
    parameter int ADDR_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter bit LATCHED_MODE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic               irq_o
);
    logic [NUM_SRC-1:0] lvl_w;
    logic [NUM_SRC-1:0] status_w;
    logic [NUM_SRC-1:0] edge_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] ack_w;
    logic [NUM_SRC-1:0] set_w;
    logic [NUM_SRC-1:0] clr_w;

    irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (src_i),
        .dout (lvl_w)
    );

    irq_pend #(.W(NUM_SRC), .LATCHED(LATCHED_MODE)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .lvl_i    (lvl_w),
        .ack_i    (ack_w),
        .status_o (status_w),
        .edge_o   (edge_w)
    );

    irq_mask_reg #(.W(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .set_i  (set_w),
        .clr_i  (clr_w),
        .mask_o (mask_w)
    );

    irq_regif #(.W(NUM_SRC), .AW(ADDR_W), .LATCHED(LATCHED_MODE)) u_regif (
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .status_i (status_w),
        .mask_i   (mask_w),
        .ack_o    (ack_w),
        .set_o    (set_w),
        .clr_o    (clr_w),
        .rdata_o  (bus_rdata)
    );

    assign irq_o = |(status_w & ~mask_w);
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
#(
    parameter int W            = 32,
    parameter int AW           = 8,
    parameter bit LATCHED_MODE = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_i,
    input logic [AW-1:0] addr_i,
    input logic [W-1:0]  wdata_i,
    input logic [W-1:0]  rdata_o,
    input logic          irq_o,
    input logic [W-1:0]  status_q,
    input logic [W-1:0]  mask_q,
    input logic [W-1:0]  edge_w
);
    reg_sel_e sel;
    assign sel = decode_sel(32'(addr_i), LATCHED_MODE);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mask_q == '1 && status_q == '0 && !irq_o));

    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_ACK) |=> ((status_q & $past(wdata_i) & ~$past(edge_w)) == '0));

    // R4
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (LATCHED_MODE && (|edge_w)) |=> ((status_q & $past(edge_w)) == $past(edge_w)));

    // R5
    mset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_MSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

    // R5
    mclr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_MCLR) |=> ((mask_q & $past(wdata_i)) == '0));

    // R6
    full_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_MSET && wdata_i == '1) |=> !irq_o);

    // R7
    mask_keeps_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (LATCHED_MODE && wr_i && sel == SEL_MSET) |=>
            ((status_q & $past(status_q)) == $past(status_q)));

    // R9
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (rdata_o == '0));

    // R9
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel == SEL_NONE) |=> $stable(mask_q));
endmodule

bind irq_agg_ctrl irq_agg_chk #(
    .W            (NUM_SRC),
    .AW           (ADDR_W),
    .LATCHED_MODE (LATCHED_MODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (bus_wr),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .rdata_o  (bus_rdata),
    .irq_o    (irq_o),
    .status_q (status_w),
    .mask_q   (mask_w),
    .edge_w   (edge_w)
);

// File: tb/test_irq_agg_ctrl.sv
`timescale 1ns/1ps
module test_irq_agg_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic        a_wr = 1'b0, b_wr = 1'b0;
    logic [7:0]  a_addr = '0, b_addr = '0;
    logic [31:0] a_wdata = '0, b_wdata = '0;
    logic [31:0] a_rdata, b_rdata;
    logic        a_irq, b_irq;

    always #10 clk = ~clk;

    irq_agg_ctrl #(.LATCHED_MODE(1'b1)) i_irq_agg_ctrl (
        .clk(clk), .rst(rst), .src_i(src), .bus_wr(a_wr), .bus_addr(a_addr),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq_o(a_irq));

    irq_agg_ctrl #(.LATCHED_MODE(1'b0)) i_irq_agg_ctrl_lvl (
        .clk(clk), .rst(rst), .src_i(src), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq_o(b_irq));

    int    total = 0;
    int    bad   = 0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [31:0] m_s1, m_s2, m_s3, m_pend, m_mask_a, m_mask_b, m_edge, m_ack;

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_s3 = '0; m_pend = '0;
            m_mask_a = '1; m_mask_b = '1;
        end else begin
            m_edge = m_s2 & ~m_s3;
            m_ack  = (a_wr && a_addr == 8'h08) ? a_wdata : '0;
            m_pend = (m_pend & ~m_ack) | m_edge;
            if (a_wr && a_addr == 8'h10) m_mask_a = m_mask_a | a_wdata;
            if (a_wr && a_addr == 8'h14) m_mask_a = m_mask_a & ~a_wdata;
            if (b_wr && b_addr == 8'h08) m_mask_b = m_mask_b | b_wdata;
            if (b_wr && b_addr == 8'h0C) m_mask_b = m_mask_b & ~b_wdata;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = src;
        end
    end

    function automatic logic [31:0] exp_rd_a(input logic [7:0] ad);
        if (ad == 8'h00) return m_pend;
        if (ad == 8'h0C) return m_mask_a;
        return '0;
    endfunction

    function automatic logic [31:0] exp_rd_b(input logic [7:0] ad);
        if (ad == 8'h00) return m_s2;
        if (ad == 8'h04) return m_mask_b;
        return '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // wait for a falling edge, then compare every output with the model
    task automatic tick();
        @(negedge clk);
        chk(cur_tag, {31'd0, a_irq}, {31'd0, |(m_pend & ~m_mask_a)});
        chk(cur_tag, {31'd0, b_irq}, {31'd0, |(m_s2 & ~m_mask_b)});
        chk(cur_tag, a_rdata, exp_rd_a(a_addr));
        chk(cur_tag, b_rdata, exp_rd_b(b_addr));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_a(input logic [7:0] ad, input logic [31:0] d);
        a_wr = 1'b1; a_addr = ad; a_wdata = d;
        tick();
        a_wr = 1'b0;
    endtask

    task automatic wr_b(input logic [7:0] ad, input logic [31:0] d);
        b_wr = 1'b1; b_addr = ad; b_wdata = d;
        tick();
        b_wr = 1'b0;
    endtask

    task automatic rd_a(input logic [7:0] ad, input logic [31:0] exp, input string tag);
        a_addr = ad;
        tick();
        chk(tag, a_rdata, exp);
    endtask

    task automatic rd_b(input logic [7:0] ad, input logic [31:0] exp, input string tag);
        b_addr = ad;
        tick();
        chk(tag, b_rdata, exp);
    endtask

    initial begin
        #(20 * 50000);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hACE1_1234;

        // R1 reset values
        cur_tag = "R1";
        idle(3);
        rst = 1'b0;
        rd_a(8'h0C, 32'hFFFF_FFFF, "R1");
        rd_a(8'h00, 32'h0, "R1");
        rd_b(8'h04, 32'hFFFF_FFFF, "R1");
        chk("R1", {31'd0, a_irq}, 32'd0);

        // R2 capture and R8 level follow
        cur_tag = "R2";
        src = 32'h21;
        idle(4);
        rd_a(8'h00, 32'h21, "R2");
        rd_b(8'h00, 32'h21, "R8");
        // R7 pending held while masked
        chk("R7", {31'd0, a_irq}, 32'd0);
        rd_a(8'h00, 32'h21, "R7");

        // R5 unmask bit 0 in each layout, R6 request rises
        cur_tag = "R5";
        wr_a(8'h14, 32'h1);
        wr_b(8'h0C, 32'h1);
        rd_a(8'h0C, 32'hFFFF_FFFE, "R5");
        rd_b(8'h04, 32'hFFFF_FFFE, "R5");
        chk("R6", {31'd0, a_irq}, 32'd1);
        chk("R6", {31'd0, b_irq}, 32'd1);

        // R10 latch survives input drop, R8 level follows it down
        cur_tag = "R10";
        src = 32'h0;
        idle(4);
        rd_a(8'h00, 32'h21, "R10");
        rd_b(8'h00, 32'h0, "R8");
        chk("R8", {31'd0, b_irq}, 32'd0);

        // R3 acknowledge bit 0 only
        cur_tag = "R3";
        wr_a(8'h08, 32'h1);
        rd_a(8'h00, 32'h20, "R3");
        chk("R3", {31'd0, a_irq}, 32'd0);

        // R4 acknowledge in the capture cycle of a new edge
        cur_tag = "R4";
        src = 32'h8;
        tick();
        tick();
        wr_a(8'h08, 32'h8);
        rd_a(8'h00, 32'h28, "R4");
        wr_a(8'h08, 32'h8);
        idle(2);
        rd_a(8'h00, 32'h20, "R4");

        // R9 unmapped offsets and the other layout's offsets
        cur_tag = "R9";
        wr_a(8'h04, 32'hFFFF_FFFF);
        wr_a(8'h18, 32'hFFFF_FFFF);
        wr_a(8'h0D, 32'hFFFF_FFFF);
        wr_b(8'h14, 32'hFFFF_FFFF);
        wr_b(8'h10, 32'hFFFF_FFFF);
        rd_a(8'h04, 32'h0, "R9");
        rd_a(8'h10, 32'h0, "R9");
        rd_a(8'h0C, 32'hFFFF_FFFE, "R9");
        rd_b(8'h04, 32'hFFFF_FFFE, "R9");
        rd_b(8'h08, 32'h0, "R9");
        rd_a(8'h00, 32'h20, "R9");

        // R5 level-mode set offset
        cur_tag = "R5";
        wr_b(8'h08, 32'h1);
        rd_b(8'h04, 32'hFFFF_FFFF, "R5");

        // R6 mixed traffic against the model
        cur_tag = "R6";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
            if (lfsr[2:0] == 3'd0) src = lfsr;
            if (lfsr[5:3] == 3'd1) begin
                a_wr = 1'b1; a_wdata = lfsr ^ 32'h5A5A_0F0F;
            end else begin
                a_wr = 1'b0;
            end
            b_wr    = a_wr;
            b_wdata = ~a_wdata;
            a_addr  = 8'(4 * (lfsr[10:8] % 3'd7));
            b_addr  = 8'(4 * (lfsr[13:11] % 3'd7));
            tick();
        end
        a_wr = 1'b0; b_wr = 1'b0;

        // R6 full mask drops the request
        wr_a(8'h10, 32'hFFFF_FFFF);
        chk("R6", {31'd0, a_irq}, 32'd0);
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule